// File: doc/BRIEF.md
# Microsecond System Timer with Compare Channels

This peripheral keeps a 64-bit count of elapsed microseconds that starts at hardware reset and cannot be stopped, loaded or cleared by software. A divider turns the input clock into a one-per-microsecond tick enable, and the count advances on each tick. Software reads the count through two read-only 32-bit words: the low half and the high half.

Four 32-bit compare channels watch the low half of the count. When the low half takes a new value that equals a channel's compare value, that channel's flag latches. The flag stays set until software writes a one to its bit in the shared status word. Each flag drives its own level interrupt pin.

Access is through a plain single-cycle register port. A write takes effect at the clock edge where the write strobe is high. Read data appears on the cycle after the read strobe. The port has no back-pressure: every strobe is accepted, and the count keeps running during any access.

Top module: `systmr_top`

## Requirements
- R1: The divider issues one tick every DIV = CLK_HZ/1_000_000 clock cycles, where DIV is an integer of at least 1. The count rises by exactly one on each tick and holds its value between ticks.
- R2: The count is 64 bits wide. Byte offset 0x04 reads bits 31:0 and offset 0x08 reads bits 63:32. Both words are read-only, and writes to them leave the count unchanged.
- R3: Compare channel i sits at byte offset 0x0C + 4*i, for i from 0 to 3. Each channel is a full 32-bit read/write register.
- R4: Status bit i (offset 0x00) is the flag of channel i. The flag is set when the low 32 count bits equal the channel's compare value. Equality is only tested in the cycle right after the count has changed, so one equality sets the flag at most once. The high 32 bits take no part in matching.
- R5: Writing a 1 to status bit i clears flag i, and writing a 0 leaves it unchanged. If a set and a clear hit the same flag at the same edge, the set wins.
- R6: irq[i] always equals flag i.
- R7: Status bits 31:4 read as zero and ignore writes. Byte offset 0x1C, and any address with bits above bit 4 set, reads as zero and ignores writes.
- R8: bus_rdata holds, on the cycle after bus_rd, the value the addressed register had at that edge. It keeps that value until the next read. Bus accesses never pause the count.
- R9: Reset clears the count, the divider, all compare registers, all flags and bus_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock, CLK_HZ hertz |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 4 | Level interrupt per compare channel |

## Verification
The assertions assume that bus_wr and bus_rd are never high together. They also assume that CLK_HZ is an exact multiple of one million, so that the tick spacing is fixed. The bench drives the strobes one at a time, from tasks that change inputs only at the falling edge. It builds the timer with a divide ratio of four, which keeps the hold interval between ticks short. With that ratio the bench can aim a status clear at the exact edge where a match sets the flag. The high count word cannot move within any affordable run, so its checks only cover the read-only and zero-after-reset behaviour.

// File: rtl/systmr_pkg.sv
package systmr_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 64;
  localparam int unsigned SLOT_LSB = 2;
  localparam int unsigned SLOT_W   = 3;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_STAT = 3'd0,
    SLOT_CLO  = 3'd1,
    SLOT_CHI  = 3'd2,
    SLOT_CMP0 = 3'd3,
    SLOT_CMP1 = 3'd4,
    SLOT_CMP2 = 3'd5,
    SLOT_CMP3 = 3'd6,
    SLOT_NONE = 3'd7
  } slot_e;
endpackage

// File: rtl/systmr_tick.sv
module systmr_tick #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign tick = 1'b1;
    end else begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DW'(DIV - 1));

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick) else $error("tick repeated"); // R1
    end
  endgenerate
endmodule

// File: rtl/systmr_count.sv
module systmr_count #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             upd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      upd <= 1'b0;
    end else begin
      if (tick) cnt <= cnt + 1'b1;
      upd <= tick;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(cnt) + 1'b1)) else $error("count step"); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)) else $error("count moved"); // R1
endmodule

// File: rtl/systmr_flags.sv
module systmr_flags #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          upd,
  input  logic [DATA_W-1:0]             cnt_lo,
  input  logic [NUM_CH-1:0]             cmp_we,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NUM_CH-1:0]             clr,
  output logic [NUM_CH-1:0][DATA_W-1:0] cmp,
  output logic [NUM_CH-1:0]             flags
);
  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit = upd && (cnt_lo == cmp[i]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cmp[i]   <= '0;
          flags[i] <= 1'b0;
        end else begin
          if (cmp_we[i]) cmp[i] <= wdata;
          flags[i] <= hit | (flags[i] & ~clr[i]);
        end
      end

      AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[i]) |-> $past(upd)) else $error("flag rose off update"); // R4
      AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !upd) |=> !flags[i]) else $error("clear lost"); // R5
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && cnt_lo == cmp[i]) |=> flags[i]) else $error("set lost"); // R5
    end
  endgenerate
endmodule

// File: rtl/systmr_top.sv
module systmr_top
  import systmr_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic [3:0]        irq
);
  localparam int unsigned DIV = CLK_HZ / 1_000_000;
  localparam int unsigned HI_LSB = SLOT_LSB + SLOT_W;

  logic                          tick, upd;
  logic [CNT_W-1:0]              cnt;
  logic [NUM_CH-1:0][DATA_W-1:0] cmp;
  logic [NUM_CH-1:0]             flags, cmp_we, clr;
  logic                          in_map;
  slot_e                         slot;
  logic [DATA_W-1:0]             rd_mux;

  systmr_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  systmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .upd(upd));

  systmr_flags #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .upd(upd), .cnt_lo(cnt[DATA_W-1:0]),
    .cmp_we(cmp_we), .wdata(bus_wdata), .clr(clr), .cmp(cmp), .flags(flags));

  assign in_map = ((bus_addr >> HI_LSB) == '0);
  assign slot   = slot_e'(bus_addr[HI_LSB-1:SLOT_LSB]);

  always_comb begin
    for (int k = 0; k < NUM_CH; k++)
      cmp_we[k] = bus_wr && in_map && (slot == slot_e'(SLOT_W'(int'(SLOT_CMP0) + k)));
    clr = (bus_wr && in_map && slot == SLOT_STAT) ? bus_wdata[NUM_CH-1:0] : '0;
  end

  always_comb begin
    rd_mux = '0;
    if (in_map) begin
      case (slot)
        SLOT_STAT: rd_mux = {{(DATA_W-NUM_CH){1'b0}}, flags};
        SLOT_CLO:  rd_mux = cnt[DATA_W-1:0];
        SLOT_CHI:  rd_mux = cnt[CNT_W-1:DATA_W];
        SLOT_CMP0: rd_mux = cmp[0];
        SLOT_CMP1: rd_mux = cmp[1];
        SLOT_CMP2: rd_mux = cmp[2];
        SLOT_CMP3: rd_mux = cmp[3];
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq = flags;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && in_map && slot == SLOT_STAT) |=> (bus_rdata[31:4] == '0))
    else $error("reserved bits set"); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)) else $error("rdata moved"); // R8
  AST_CNT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !tick) |=> $stable(cnt)) else $error("count written"); // R2
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[0]) |-> $past(upd)) else $error("irq rose off update"); // R6
endmodule

// File: tb/sim_systmr_top.sv
module sim_systmr_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 4_000_000;
  localparam int DIV = CLK_HZ / 1_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  systmr_top #(.CLK_HZ(CLK_HZ), .ADDR_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int          m_div;
  logic [63:0] m_cnt;
  bit          m_new;
  logic [31:0] m_cmp [4];
  bit   [3:0]  m_flag;
  logic [31:0] m_rdata;
  string       m_rtag = "R9";

  function automatic logic [31:0] m_read(logic [4:0] a);
    case (a[4:2])
      3'd0: return {28'd0, m_flag};
      3'd1: return m_cnt[31:0];
      3'd2: return m_cnt[63:32];
      3'd3, 3'd4, 3'd5, 3'd6: return m_cmp[int'(a[4:2]) - 3];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [4:0] a);
    case (a[4:2])
      3'd0: return "R5";
      3'd1: return "R1";
      3'd2: return "R2";
      3'd7: return "R7";
      default: return "R3";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_new = 0; m_flag = 0; m_rdata = 0;
      for (int k = 0; k < 4; k++) m_cmp[k] = 0;
    end else begin
      bit tk;
      bit [3:0] nf;
      tk = (m_div == DIV - 1);
      for (int k = 0; k < 4; k++) begin
        bit st, cl;
        st = m_new && (m_cnt[31:0] == m_cmp[k]);
        cl = bus_wr && bus_addr == 5'h00 && bus_wdata[k];
        nf[k] = st || (m_flag[k] && !cl);
      end
      if (bus_rd) begin
        m_rdata = m_read(bus_addr);
        m_rtag = tag_of(bus_addr);
      end
      if (bus_wr && bus_addr[4:2] >= 3 && bus_addr[4:2] <= 6)
        m_cmp[int'(bus_addr[4:2]) - 3] = bus_wdata;
      m_flag = nf;
      if (tk) m_cnt = m_cnt + 1;
      m_new = tk;
      m_div = tk ? 0 : m_div + 1;
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(irq == m_flag, "R6 irq", irq, m_flag);
      chk(bus_rdata == m_rdata, {m_rtag, " R8 rdata"}, bus_rdata, m_rdata);
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [31:0] v, v2;
    do_reset();
    // R9: reset state
    rd(5'h0C, v); chk(v == 0, "R9 cmp0 after reset", v, 0);
    rd(5'h00, v); chk(v == 0, "R9 status after reset", v, 0);
    rd(5'h08, v); chk(v == 0, "R2 high word zero", v, 0);
    // R1 / R8: count advances during accesses
    rd(5'h04, v);
    repeat (7) @(negedge clk);
    rd(5'h04, v2);
    chk(v2 - v == 2, "R1 R8 two ticks in eight cycles", v2 - v, 2);
    // R3: compare registers read back
    for (int k = 0; k < 4; k++) wr(5'(12 + 4*k), 32'hA5A5_0000 + k);
    for (int k = 0; k < 4; k++) begin
      rd(5'(12 + 4*k), v);
      chk(v == 32'hA5A5_0000 + k, "R3 compare readback", v, 32'hA5A5_0000 + k);
    end
    // R4: matches on near values
    for (int k = 0; k < 4; k++) wr(5'(12 + 4*k), m_cnt[31:0] + 3 + 2*k);
    repeat (50) @(negedge clk);
    rd(5'h00, v); chk(v == 32'hF, "R4 all flags set", v, 32'hF);
    // R5: zero write keeps, one write clears
    wr(5'h00, 32'h0);
    rd(5'h00, v); chk(v == 32'hF, "R5 zero write keeps", v, 32'hF);
    wr(5'h00, 32'h3);
    rd(5'h00, v); chk(v == 32'hC, "R5 clear ch0 ch1", v, 32'hC);
    // R4: no re-set while count holds at the match value
    wr(5'h00, 32'hF);
    repeat (12) @(negedge clk);
    rd(5'h00, v); chk(v == 0, "R4 single set per equality", v, 0);
    // R5: set wins over simultaneous clear on ch2
    wr(5'h14, m_cnt[31:0] + 2);
    wr(5'h00, 32'h0);
    while (!(m_new && m_cnt[31:0] == m_cmp[2])) @(negedge clk);
    wr(5'h00, 32'h4);
    chk(irq[2] == 1'b1, "R5 set wins", irq[2], 1);
    // R2: count words ignore writes
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, v); chk(v == 0, "R2 high word write ignored", v, 0);
    rd(5'h04, v); chk(v < 32'h1000, "R2 low word write ignored", v, 32'h1000);
    // R7: reserved bits and unmapped slot
    wr(5'h00, 32'hFFFF_FFF0);
    rd(5'h00, v); chk(v[31:4] == 0, "R7 reserved bits zero", v, 32'h4);
    wr(5'h1C, 32'h1234_5678);
    rd(5'h1C, v); chk(v == 0, "R7 unmapped reads zero", v, 0);
    // R9: reset mid-run
    repeat (5) @(negedge clk);
    do_reset();
    rd(5'h04, v); chk(v == 0, "R9 count cleared", v, 0);
    rd(5'h18, v); chk(v == 0, "R9 compare cleared", v, 0);
    chk(irq == 0, "R9 irq cleared", irq, 0);
    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule